// File: doc/BRIEF.md
# I2C Target Presence Scanner

This block sweeps an I2C bus for responding targets. A single start pulse makes it probe every non-reserved 7-bit address in ascending order. Each probe is a START, an address byte that carries the write direction, a ninth clock on which the block releases the data line and listens, and then a STOP. When a target pulls the data line low on that ninth clock, the block sets the bit for that address in a 128-bit presence map and increments a found counter. When the sweep ends, the block drops busy and raises done.

The block drives the two bus wires through open-drain style pull-low enables and reads the real line levels back through synchronizers. Every release of the clock line is followed by a wait until the line actually reads high, so a target that holds the clock low only slows the sweep down. A divisor input sets the length of each clock phase. Reading device data, 10-bit addressing and recovery of a stuck bus are not part of this block.

Top module: `addrSweeper`

## Requirements
- R1: One sweep probes addresses 0x08 to 0x77 inclusive, once each, in ascending order (112 probes), and no other address.
- R2: Each probe's address byte is the 7-bit address sent MSB first, followed by a direction bit of 0 (write). Eight data clocks carry these bits, and a ninth clock follows.
- R3: Each probe opens with a START (data falls while the clock line is high) and closes with a STOP (data rises while the clock line is high). At all other times the data pull changes only while the block holds the clock low.
- R4: The map bit at index A is 1 when the data line reads low at the end of the ninth-clock high phase of A's probe, and 0 when it reads high.
- R5: Map bits 0 to 7 and 120 to 127 read 0 after any sweep, whatever targets sit at those addresses.
- R6: When done is high, the found count equals the number of 1 bits in the map.
- R7: A start pulse while idle clears the map and the count, raises busy and lowers done. When the last probe finishes, busy falls and done rises. done and busy are never both high.
- R8: Each clock-low phase lasts exactly max(divisor,2) cycles. After the block releases the clock, it begins timing the high phase only once the line reads high, so a target holding the clock low lengthens the phase without corrupting the probe.
- R9: After reset, both pull enables, busy, done, the map and the count are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Begins a sweep when idle |
| divisor | input | DIV_W | Clock-phase length in cycles (values below 2 act as 2) |
| sclIn | input | 1 | Clock line level as seen on the bus |
| sdaIn | input | 1 | Data line level as seen on the bus |
| sclPullLow | output | 1 | 1 pulls the clock line low, 0 releases it |
| sdaPullLow | output | 1 | 1 pulls the data line low, 0 releases it |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Last sweep completed |
| presentMap | output | 128 | Bit A is 1 when address A acknowledged |
| foundCount | output | 8 | Number of acknowledging addresses |

## Verification
The bench models a bus with open-drain wiring and a set of targets that acknowledge their own addresses. Some of these targets sit at reserved addresses; a design that probed outside the window, or left map bits set there, would report them. Targets also hold the clock low for random lengths. A design that timed the high phase from its own release instead of from the line would sample too early, and the bench would see wrong address bytes and a wrong map. Back-to-back sweeps over a full set of targets and then an empty one expose a design that fails to clear the map. The bench also counts STARTs and STOPs and measures phase lengths, which catches a missed ninth clock, a data change while the clock is high, or a divisor that is not applied.

// File: rtl/sweepPkg.sv
package sweepPkg;
  localparam int ADDR_W     = 7;
  localparam int MAP_W      = 1 << ADDR_W;
  localparam int COUNT_W    = $clog2(MAP_W + 1);
  localparam int SLOTS      = 9;
  localparam int SLOT_W     = $clog2(SLOTS + 1);
  localparam logic [ADDR_W-1:0] FIRST_ADDR = 7'h08;
  localparam logic [ADDR_W-1:0] LAST_ADDR  = 7'h77;
  localparam logic DIR_WRITE = 1'b0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_BUSFREE, ST_START, ST_BITLO, ST_BITHI, ST_STOPLO, ST_STOPHI, ST_STOPREL
  } seqState_t;

  typedef struct packed {
    logic clearAll;
    logic nextBit;
    logic recordAck;
    logic nextAddr;
  } dpCmd_t;
endpackage

// File: rtl/sweepDatapath.sv
module sweepDatapath
  import sweepPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCmd_t             cmd,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sclHigh,
  output logic               sdaHigh,
  output logic               txBit,
  output logic               lastBit,
  output logic               lastAddr,
  output logic [MAP_W-1:0]   presentMap,
  output logic [COUNT_W-1:0] foundCount
);
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic [ADDR_W-1:0]      curAddr;
  logic [SLOT_W-1:0]      bitIdx;
  logic [7:0]             addrByte;
  logic [2:0]             bitSel;

  // line synchronizers; idle bus reads high
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
        end
    end
  endgenerate

  assign sclHigh  = sclPipe[SYNC_STAGES-1];
  assign sdaHigh  = sdaPipe[SYNC_STAGES-1];
  assign addrByte = {curAddr, DIR_WRITE};
  assign bitSel   = 3'(SLOT_W'(7) - bitIdx);
  assign txBit    = (bitIdx < SLOT_W'(8)) ? addrByte[bitSel] : 1'b1;
  assign lastBit  = (bitIdx == SLOT_W'(SLOTS - 1));
  assign lastAddr = (curAddr == LAST_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr    <= FIRST_ADDR;
      bitIdx     <= '0;
      presentMap <= '0;
      foundCount <= '0;
    end else if (cmd.clearAll) begin
      curAddr    <= FIRST_ADDR;
      bitIdx     <= '0;
      presentMap <= '0;
      foundCount <= '0;
    end else begin
      if (cmd.nextBit) bitIdx <= bitIdx + SLOT_W'(1);
      if (cmd.recordAck) begin
        presentMap[curAddr] <= !sdaHigh;
        if (!sdaHigh) foundCount <= foundCount + COUNT_W'(1);
      end
      if (cmd.nextAddr) begin
        curAddr <= curAddr + ADDR_W'(1);
        bitIdx  <= '0;
      end
    end
  end

  AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (curAddr >= FIRST_ADDR) && (curAddr <= LAST_ADDR)); // R1
  AST_MAP_EDGES_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (presentMap[7:0] == '0) && (presentMap[MAP_W-1:120] == '0)); // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (foundCount == $past(foundCount)) || (foundCount == $past(foundCount) + COUNT_W'(1))
             || (foundCount == '0)); // R6
endmodule

// File: rtl/sweepCtrl.sv
module sweepCtrl
  import sweepPkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int MIN_PHASE = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [DIV_W-1:0] divisor,
  input  logic             sclHigh,
  input  logic             sdaHigh,
  input  logic             txBit,
  input  logic             lastBit,
  input  logic             lastAddr,
  output dpCmd_t           cmd,
  output logic             sclPullLow,
  output logic             sdaPullLow,
  output logic             busy,
  output logic             done
);
  seqState_t        state, nxt;
  logic [DIV_W-1:0] tmr, phaseLen;
  logic             tmrDone, load, sdaPullNext, finish;

  assign phaseLen = (divisor < DIV_W'(MIN_PHASE)) ? DIV_W'(MIN_PHASE) : divisor;
  assign tmrDone  = (tmr == '0);

  always_comb begin
    nxt = state;
    cmd = '0;
    load = 1'b0;
    finish = 1'b0;
    sclPullLow = 1'b0;
    sdaPullNext = 1'b0;
    unique case (state)
      ST_IDLE:
        if (startPulse) begin
          cmd.clearAll = 1'b1;
          nxt = ST_BUSFREE;
          load = 1'b1;
        end
      ST_BUSFREE:
        if (!sclHigh || !sdaHigh) load = 1'b1;
        else if (tmrDone) begin
          nxt = ST_START;
          load = 1'b1;
        end
      ST_START: begin
        sdaPullNext = 1'b1;
        if (tmrDone) begin
          nxt = ST_BITLO;
          load = 1'b1;
        end
      end
      ST_BITLO: begin
        sclPullLow = 1'b1;
        sdaPullNext = !txBit;
        if (tmrDone) begin
          nxt = ST_BITHI;
          load = 1'b1;
        end
      end
      ST_BITHI: begin
        sdaPullNext = !txBit;
        if (!sclHigh) load = 1'b1;
        else if (tmrDone) begin
          load = 1'b1;
          if (lastBit) begin
            cmd.recordAck = 1'b1;
            nxt = ST_STOPLO;
          end else begin
            cmd.nextBit = 1'b1;
            nxt = ST_BITLO;
          end
        end
      end
      ST_STOPLO: begin
        sclPullLow = 1'b1;
        sdaPullNext = 1'b1;
        if (tmrDone) begin
          nxt = ST_STOPHI;
          load = 1'b1;
        end
      end
      ST_STOPHI: begin
        sdaPullNext = 1'b1;
        if (!sclHigh) load = 1'b1;
        else if (tmrDone) begin
          nxt = ST_STOPREL;
          load = 1'b1;
        end
      end
      ST_STOPREL:
        if (tmrDone) begin
          if (lastAddr) begin
            nxt = ST_IDLE;
            finish = 1'b1;
          end else begin
            cmd.nextAddr = 1'b1;
            nxt = ST_BUSFREE;
            load = 1'b1;
          end
        end
      default: nxt = ST_IDLE;
    endcase
  end

  // data pull lags the clock pull by one cycle so the two never move together
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      tmr        <= '0;
      sdaPullLow <= 1'b0;
      done       <= 1'b0;
    end else begin
      state      <= nxt;
      sdaPullLow <= sdaPullNext;
      if (load) tmr <= phaseLen - DIV_W'(1);
      else if (!tmrDone) tmr <= tmr - DIV_W'(1);
      if (cmd.clearAll) done <= 1'b0;
      else if (finish) done <= 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);

  AST_SAMPLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    cmd.recordAck |-> sclHigh); // R4
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaPullLow) && !sclPullLow) |-> (state == ST_START || state == ST_STOPREL)); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R7
  AST_LOW_PHASE_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BITLO && !tmrDone) |=> state == ST_BITLO); // R8
endmodule

// File: rtl/addrSweeper.sv
module addrSweeper
  import sweepPkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic [DIV_W-1:0]   divisor,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sclPullLow,
  output logic               sdaPullLow,
  output logic               busy,
  output logic               done,
  output logic [MAP_W-1:0]   presentMap,
  output logic [COUNT_W-1:0] foundCount
);
  dpCmd_t cmd;
  logic   sclHigh, sdaHigh, txBit, lastBit, lastAddr;

  sweepCtrl #(.DIV_W(DIV_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .divisor(divisor),
    .sclHigh(sclHigh), .sdaHigh(sdaHigh), .txBit(txBit), .lastBit(lastBit),
    .lastAddr(lastAddr), .cmd(cmd), .sclPullLow(sclPullLow),
    .sdaPullLow(sdaPullLow), .busy(busy), .done(done)
  );

  sweepDatapath #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclHigh(sclHigh), .sdaHigh(sdaHigh), .txBit(txBit), .lastBit(lastBit),
    .lastAddr(lastAddr), .presentMap(presentMap), .foundCount(foundCount)
  );
endmodule

// File: tb/test_addrSweeper.sv
`timescale 1ns/1ps
module test_addrSweeper;
  logic         clk = 1'b0;
  logic         rstN = 1'b1;
  logic         startPulse = 1'b0;
  logic [15:0]  divisor = 16'd4;
  logic         sclPullLow, sdaPullLow, busy, done;
  logic [127:0] presentMap;
  logic [7:0]   foundCount;

  logic         tbSclHold = 1'b0, ackHold = 1'b0;
  logic         sclLine, sdaLine;
  logic [127:0] devSet = '0;
  bit           monOn = 1'b0, stretchOn = 1'b0, hung = 1'b0;
  int           nChecks = 0, nFails = 0;
  int           startsSeen, stopsSeen, addrErrs, bitCnt;
  logic [7:0]   shifter;
  logic [6:0]   expAddr;
  bit           active = 1'b0;
  int           lowRun, minLow, maxLow, highRun, minHigh;

  always #5 clk = ~clk;

  assign sclLine = ~sclPullLow & ~tbSclHold;
  assign sdaLine = ~sdaPullLow & ~ackHold;

  addrSweeper i_addrSweeper (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .divisor(divisor),
    .sclIn(sclLine), .sdaIn(sdaLine), .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow),
    .busy(busy), .done(done), .presentMap(presentMap), .foundCount(foundCount)
  );

  // bus monitor and target model
  always @(negedge sdaLine) if (monOn && sclLine) begin
    startsSeen++;
    active = 1'b1;
    bitCnt = 0;
    shifter = '0;
  end
  always @(posedge sdaLine) if (monOn && sclLine) stopsSeen++;
  always @(posedge sclLine) if (monOn && active) begin
    if (bitCnt < 8) begin
      shifter = {shifter[6:0], sdaLine};
      if (bitCnt == 7) begin
        if (shifter != {expAddr, 1'b0}) addrErrs++;
        expAddr = expAddr + 7'd1;
      end
    end
    bitCnt++;
  end
  always @(negedge sclLine) if (monOn && active) begin
    if (bitCnt == 8 && shifter[0] == 1'b0 && devSet[shifter[7:1]]) ackHold = 1'b1;
    else if (bitCnt == 9) begin
      ackHold = 1'b0;
      active = 1'b0;
    end
  end
  // targets stretching the clock after each falling edge
  always @(negedge sclLine) if (monOn && stretchOn) begin : stretchBlk
    int n;
    n = $urandom_range(0, 6);
    if (n > 0) begin
      tbSclHold = 1'b1;
      repeat (n) @(posedge clk);
      tbSclHold = 1'b0;
    end
  end
  // phase length measurement
  always @(negedge clk) if (monOn) begin
    if (sclPullLow) lowRun++;
    else if (lowRun > 0) begin
      if (lowRun < minLow) minLow = lowRun;
      if (lowRun > maxLow) maxLow = lowRun;
      lowRun = 0;
    end
    if (sclLine) highRun++;
    else if (highRun > 0) begin
      if (highRun < minHigh) minHigh = highRun;
      highRun = 0;
    end
  end

  function automatic logic [127:0] expMap(input logic [127:0] dev);
    logic [127:0] m = '0;
    for (int a = 8; a <= 119; a++) m[a] = dev[a];
    return m;
  endfunction

  function automatic int popCount(input logic [127:0] v);
    int c = 0;
    for (int i = 0; i < 128; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic runSweep(input logic [127:0] dev, input int div, input bit stretch);
    int phase, cyc;
    phase = (div < 2) ? 2 : div;
    devSet = dev;
    divisor = 16'(div);
    stretchOn = stretch;
    startsSeen = 0; stopsSeen = 0; addrErrs = 0; expAddr = 7'h08;
    lowRun = 0; highRun = 0; minLow = 1 << 30; maxLow = 0; minHigh = 1 << 30;
    @(negedge clk) startPulse = 1'b1;
    @(negedge clk) startPulse = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy && !done, "R7 busy after start", {busy, done}, 2'b10);
    chk(presentMap == '0 && foundCount == 0, "R7 map cleared by start", presentMap, 0);
    cyc = 0;
    while (!done && cyc < 45000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      hung = 1'b1;
      chk(1'b0, "R7 watchdog expired waiting for done", cyc, 45000);
      return;
    end
    repeat (2) @(negedge clk);
    chk(presentMap == expMap(dev), "R4 presence map", presentMap, expMap(dev));
    chk(presentMap[7:0] == 0 && presentMap[127:120] == 0, "R5 reserved bits zero",
        {presentMap[127:120], presentMap[7:0]}, 0);
    chk(int'(foundCount) == popCount(expMap(dev)), "R6 found count", foundCount, popCount(expMap(dev)));
    chk(done && !busy, "R7 done and not busy", {done, busy}, 2'b10);
    chk(startsSeen == 112, "R3 START count", startsSeen, 112);
    chk(stopsSeen == 112, "R3 STOP count", stopsSeen, 112);
    chk(expAddr == 7'h78, "R1 probes in window", expAddr, 7'h78);
    chk(addrErrs == 0, "R2 address byte content and order", addrErrs, 0);
    chk(minLow == phase && maxLow == phase, "R8 clock-low phase length", {minLow, maxLow}, {phase, phase});
    chk(minHigh >= phase, "R8 clock-high phase under stretching", minHigh, phase);
  endtask

  initial begin : mainSeq
    logic [127:0] rnd;
    void'($urandom(32'd7331));
    #1 rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!sclPullLow && !sdaPullLow, "R9 lines released", {sclPullLow, sdaPullLow}, 0);
    chk(!busy && !done, "R9 idle status", {busy, done}, 0);
    chk(presentMap == 0 && foundCount == 0, "R9 map and count zero", presentMap, 0);
    monOn = 1'b1;

    runSweep({128{1'b1}}, 2, 1'b0);               // every address answers, reserved too
    if (!hung) runSweep('0, 3, 1'b1);             // empty bus after full: map must clear
    rnd = {$urandom, $urandom, $urandom, $urandom};
    rnd[8] = 1'b1; rnd[119] = 1'b1; rnd[7] = 1'b1; rnd[120] = 1'b1;
    if (!hung) runSweep(rnd, 2, 1'b1);            // random targets with stretching
    rnd = {$urandom, $urandom, $urandom, $urandom};
    rnd[8] = 1'b0; rnd[119] = 1'b1;
    if (!hung) runSweep(rnd, 0, 1'b0);            // divisor below minimum

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule